// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block turns a serial audio stream into parallel samples. The stream has three lines: a bit clock, a word clock and one data line. All three are sampled as slow inputs in the system clock domain. A 5-bit control register picks the framing: stereo I2S, stereo left-justified, stereo right-justified (24, 20, 18 or 16 valid bits), or eight-slot TDM on the single data line. The same register also sets which word clock level carries the left channel (in TDM, which edge starts a frame) and which bit clock edge samples the data.

Each completed sample appears for one system clock cycle. It is 24 bits wide and MSB-aligned, and it carries a channel index. Stereo channels run for 32 bit clocks each, and TDM slots are also 32 bit clocks each. In TDM the word clock may be a 50% clock or a short pulse. Only the edge that opens a frame is used. The system clock must be at least four times faster than the bit clock.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset the control register holds 0, which selects I2S with both polarity bits clear, and `smp_valid` is low. A stream sent without any register write is decoded as I2S.
- R2: The mode field is cfg bits [2:0]. The codes are: 0 = I2S, 1 = left-justified, 2 = TDM, 3/4/5/6 = right-justified with 24/20/18/16 bits, 7 = reserved.
- R3: In I2S the MSB is the second bit after a word clock change. 24 bits are captured.
- R4: In left-justified mode the MSB is the first bit after a word clock change. 24 bits are captured.
- R5: In right-justified modes the LSB is the last of the 32 bits of a channel. The captured W bits appear in `smp_data[23:24-W]`, and the lower bits are zero.
- R6: Cfg bit 4 is the word clock polarity. In stereo modes, when it is 0 the left channel (index 0) is sent with the word clock low and the right channel (index 1) with it high. When it is 1, the two are swapped.
- R7: Cfg bit 3 is the bit clock polarity. When it is 0, data is sampled on the rising bit clock edge and may change on the falling edge. When it is 1, both edges are reversed.
- R8: In TDM, a frame begins at the first bit after the word clock moves to its active level: low when bit 4 is 0, high when bit 4 is 1. The frame holds eight 32-bit slots with indexes 0 to 7. Within each slot the MSB is the slot's second bit and 24 bits are captured.
- R9: In TDM, a word clock return to the inactive level in the middle of a frame does not restart the frame. A one-bit pulse and a half-frame clock give the same samples.
- R10: With the reserved mode code, `smp_valid` never rises.
- R11: Each sample is signalled by `smp_valid` high for exactly one cycle, together with `smp_chan` and `smp_data`.
- R12: A write loads `cfg_wdata` into the control register, using the bit layout given in R2, R6 and R7. The new settings take effect for the stream that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control value: [4] word clock polarity, [3] bit clock polarity, [2:0] mode |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| lrclk_in | input | 1 | Serial word clock or frame pulse (asynchronous) |
| sdata_in | input | 1 | Serial data |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 3 | Channel index of the sample |
| smp_data | output | 24 | MSB-aligned sample |

## Verification
In every stream, the bits outside the capture window are driven to one. A window placed one bit early or late, or one that is too wide, therefore shows up as wrong sample bits or wrong low-bit fill. All four right-justified widths are run, so a wrong width lookup or shift corrupts either the top bits or the zero fill. The polarity tests change data a little after the non-sampling edge. A receiver that samples on the wrong edge then reads the previous bit and shifts the whole word. The TDM tests use both a one-bit pulse and a half-frame clock. A receiver that restarts on the mid-frame word clock edge would repeat slots 0 to 3 and never deliver slots 4 to 7. In the reserved mode, a full stereo stream must produce no strobe at all.

// File: rtl/sar_pkg.sv
// Shared types and decode helpers for the serial audio receiver.
// Assumes: the mode field occupies the low three bits of the control word.
package sar_pkg;

    typedef enum logic [2:0] {
        MODE_I2S  = 3'b000,
        MODE_LJ   = 3'b001,
        MODE_TDM  = 3'b010,
        MODE_RJ24 = 3'b011,
        MODE_RJ20 = 3'b100,
        MODE_RJ18 = 3'b101,
        MODE_RJ16 = 3'b110,
        MODE_RSV  = 3'b111
    } rx_mode_e;

    typedef struct packed {
        logic     ws_inv;   // word clock polarity
        logic     bck_inv;  // bit clock edge select
        rx_mode_e mode;
    } rx_cfg_t;

    // Number of captured bits for a mode; full is the sample width.
    function automatic logic [5:0] word_bits(rx_mode_e m, logic [5:0] full);
        case (m)
            MODE_RJ20: word_bits = 6'd20;
            MODE_RJ18: word_bits = 6'd18;
            MODE_RJ16: word_bits = 6'd16;
            default:   word_bits = full;
        endcase
    endfunction

    // Modes whose MSB trails the slot boundary by one bit.
    function automatic logic msb_delayed(rx_mode_e m);
        msb_delayed = (m == MODE_I2S) || (m == MODE_TDM);
    endfunction

    // Modes that justify the LSB to the end of the channel.
    function automatic logic is_rj(rx_mode_e m);
        is_rj = (m == MODE_RJ24) || (m == MODE_RJ20) ||
                (m == MODE_RJ18) || (m == MODE_RJ16);
    endfunction

endpackage

// File: rtl/sar_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: all bits are slow compared with clk, so the same latency for every bit keeps them aligned.
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_edge.sv
// Detects the sampling edge of the synchronized bit clock.
// Assumes: bclk_s is already synchronous; bck_inv = 0 selects the rising edge.
module sar_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s,
    input  logic bck_inv,
    output logic strobe
);
    logic prev;

    // Remember last cycle's bit clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= bclk_s;
    end

    // A sampling edge is a change that lands on the active level.
    always_comb strobe = (bclk_s != prev) && (bclk_s == !bck_inv);
endmodule

// File: rtl/sar_slot_ctl.sv
// Tracks bit position within a channel or TDM frame and decides which
// sampled bits belong to a sample window and which one closes it.
// Assumes: strobe marks each sampling edge; lr_s is aligned with it.
module sar_slot_ctl
    import sar_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int SLOTS     = 8,
    parameter int CH_W      = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            strobe,
    input  logic            lr_s,
    input  rx_cfg_t         cfg,
    input  logic [5:0]      width,
    output logic            take,
    output logic            last,
    output logic [CH_W-1:0] chan
);
    localparam int FRAME_LEN = SLOTS * SLOT_BITS;
    localparam int POS_W     = $clog2(FRAME_LEN + 1);
    localparam int BIT_W     = $clog2(SLOT_BITS);
    localparam logic [POS_W-1:0] POS_MAX   = POS_W'(FRAME_LEN);
    localparam logic [POS_W-1:0] POS_HALF  = POS_W'(SLOT_BITS);
    localparam logic [BIT_W:0]   SLOT_LEN  = (BIT_W+1)'(SLOT_BITS);

    logic             have_prev, lr_prev, locked;
    logic [POS_W-1:0] pos;

    logic             tdm, edge_seen, frame_go, lock_cur, in_win;
    logic [POS_W-1:0] limit, pos_cur;
    logic [BIT_W:0]   bit_idx, first, final_bit;

    // Frame restart, bit position and window decisions for the current bit.
    always_comb begin
        tdm       = (cfg.mode == MODE_TDM);
        edge_seen = have_prev && (lr_s != lr_prev);
        frame_go  = tdm ? (edge_seen && (lr_s == cfg.ws_inv)) : edge_seen;
        limit     = tdm ? POS_MAX : POS_HALF;
        if (frame_go)         pos_cur = '0;
        else if (pos < limit) pos_cur = pos + 1'b1;
        else                  pos_cur = pos;
        lock_cur  = locked || frame_go;
        bit_idx   = {1'b0, pos_cur[BIT_W-1:0]};
        if (msb_delayed(cfg.mode))  first = (BIT_W+1)'(1);
        else if (is_rj(cfg.mode))   first = SLOT_LEN - width;
        else                        first = '0;
        final_bit = first + width - 1'b1;
        in_win    = lock_cur && (cfg.mode != MODE_RSV) && (pos_cur < limit) &&
                    (bit_idx >= first) && (bit_idx <= final_bit);
        take      = strobe && in_win;
        last      = (bit_idx == final_bit);
        if (tdm) chan = pos_cur[BIT_W +: CH_W];
        else     chan = {{(CH_W-1){1'b0}}, lr_s ^ cfg.ws_inv};
    end

    // Advance the position and alignment state on every sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have_prev <= 1'b0;
            lr_prev   <= 1'b0;
            locked    <= 1'b0;
            pos       <= POS_MAX;
        end else if (strobe) begin
            have_prev <= 1'b1;
            lr_prev   <= lr_s;
            locked    <= lock_cur;
            pos       <= pos_cur;
        end
    end
endmodule

// File: rtl/sar_deser.sv
// Shifts window bits in MSB first and publishes an MSB-aligned sample with
// a one-cycle strobe when the window closes.
// Assumes: take and last come from the same sampling edge as sd.
module sar_deser #(
    parameter int SAMPLE_W = 24,
    parameter int CH_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                last,
    input  logic                sd,
    input  logic [CH_W-1:0]     chan,
    input  logic [5:0]          width,
    output logic                valid,
    output logic [CH_W-1:0]     chan_o,
    output logic [SAMPLE_W-1:0] data_o
);
    logic [SAMPLE_W-1:0] shreg, nxt;

    // Shift register contents including the bit arriving now.
    always_comb nxt = {shreg[SAMPLE_W-2:0], sd};

    // Capture window bits and emit the aligned sample on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            valid  <= 1'b0;
            chan_o <= '0;
            data_o <= '0;
        end else begin
            valid <= take && last;
            if (take) shreg <= nxt;
            if (take && last) begin
                chan_o <= chan;
                data_o <= nxt << (6'(SAMPLE_W) - width);
            end
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
// Serial audio input receiver: control register, input synchronizers,
// bit clock edge selection, frame tracking and deserialization.
// Assumes: clk runs at least four times faster than bclk_in.
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int SLOTS     = 8,
    parameter int SYNC_STG  = 2,
    parameter int CH_W      = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_wdata,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    output logic                smp_valid,
    output logic [CH_W-1:0]     smp_chan,
    output logic [SAMPLE_W-1:0] smp_data
);
    rx_cfg_t         cfg_q;
    logic [2:0]      pins_s;
    logic            bclk_s, lr_s, sd_s, strobe, take, last;
    logic [CH_W-1:0] chan;
    logic [5:0]      width;

    // Control register load.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= rx_cfg_t'(cfg_wdata);
    end

    // Captured width for the current mode.
    always_comb width = word_bits(cfg_q.mode, 6'(SAMPLE_W));

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bclk_in, lrclk_in, sdata_in}), .q(pins_s)
    );
    assign {bclk_s, lr_s, sd_s} = pins_s;

    sar_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s),
        .bck_inv(cfg_q.bck_inv), .strobe(strobe)
    );

    sar_slot_ctl #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .CH_W(CH_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .clr(cfg_we), .strobe(strobe),
        .lr_s(lr_s), .cfg(cfg_q), .width(width),
        .take(take), .last(last), .chan(chan)
    );

    sar_deser #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .take(take), .last(last), .sd(sd_s),
        .chan(chan), .width(width),
        .valid(smp_valid), .chan_o(smp_chan), .data_o(smp_data)
    );
endmodule

// File: rtl/sar_checker.sv
// Property checks on the receiver's outputs against its control register.
// Assumes: widths match the receiver defaults.
module sar_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  cfg_q,
    input logic        smp_valid,
    input logic [2:0]  smp_chan,
    input logic [23:0] smp_data
);
    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R10
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2:0] == 3'b111 && $past(cfg_q[2:0]) == 3'b111) |-> !smp_valid);

    // R5
    rj16_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_q[2:0] == 3'b110 && $past(cfg_q[2:0]) == 3'b110)
        |-> smp_data[7:0] == 8'h00);

    // R5
    rj20_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_q[2:0] == 3'b100 && $past(cfg_q[2:0]) == 3'b100)
        |-> smp_data[3:0] == 4'h0);

    // R6
    stereo_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_q[2:0] != 3'b010 && $past(cfg_q[2:0]) != 3'b010)
        |-> smp_chan <= 3'd1);
endmodule

bind serial_audio_rx sar_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
    logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic        bclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
    logic        smp_valid;
    logic [2:0]  smp_chan;
    logic [23:0] smp_data;

    serial_audio_rx dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
    );

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, n_obs = 0, n_exp = 0, n_dbl = 0;
    logic [2:0]  obs_ch [64];
    logic [23:0] obs_d  [64];
    logic [2:0]  exp_ch [64];
    logic [23:0] exp_d  [64];
    logic        prev_v = 1'b0;

    // Collect samples away from the active edge.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (n_obs < 64) begin
                obs_ch[n_obs] = smp_chan;
                obs_d[n_obs]  = smp_data;
            end
            n_obs++;
            if (prev_v) n_dbl++;
        end
        prev_v = smp_valid;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic write_cfg(logic [4:0] v);
        cfg_wdata = v; cfg_we = 1'b1; tick(1); cfg_we = 1'b0; tick(4);
    endtask

    // Data changes shortly after the non-sampling edge.
    task automatic send_bit(logic d, logic lr, logic ibp);
        bclk_in = ibp; tick(1);
        sdata_in = d; lrclk_in = lr; tick(3);
        bclk_in = ~ibp; tick(4);
    endtask

    function automatic int wbits(logic [2:0] m);
        case (m)
            3'd4: return 20;
            3'd5: return 18;
            3'd6: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [31:0] word32(logic [2:0] m, logic [23:0] v);
        logic [31:0] w;
        int wd = wbits(m);
        case (m)
            3'd0: w = {1'b1, v, 7'h7F};
            3'd1: w = {v, 8'hFF};
            default: begin
                w = 32'(v >> (24 - wd));
                for (int b = wd; b < 32; b++) w[b] = 1'b1;
            end
        endcase
        return w;
    endfunction

    function automatic logic [23:0] mkval(int seed, int a, int b);
        return 24'h5A3C96 ^ 24'(seed * 24'h13579 + a * 24'h2468B + b * 24'h11111);
    endfunction

    task automatic compare(string req);
        check({req, " count"}, n_obs, n_exp);
        check("R11 single-cycle strobe", n_dbl, 0);
        for (int i = 0; i < n_exp && i < n_obs && i < 64; i++) begin
            check({req, " chan"}, int'(obs_ch[i]), int'(exp_ch[i]));
            check({req, " data"}, int'(obs_d[i]), int'(exp_d[i]));
        end
    endtask

    task automatic run_stereo(string req, logic wr, logic [2:0] mode,
                              logic ilp, logic ibp, int seed, logic quiet);
        if (wr) write_cfg({ilp, ibp, mode});
        n_obs = 0; n_exp = 0; n_dbl = 0;
        repeat (4) send_bit(1'b0, ~ilp, ibp);
        for (int p = 0; p < 2; p++) begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] v = mkval(seed, p, h);
                logic [31:0] w = word32(mode, v);
                int wd = wbits(mode);
                for (int b = 31; b >= 0; b--) send_bit(w[b], h ? ~ilp : ilp, ibp);
                if (!quiet) begin
                    exp_ch[n_exp] = 3'(h);
                    exp_d[n_exp]  = (v >> (24 - wd)) << (24 - wd);
                    n_exp++;
                end
            end
        end
        repeat (2) send_bit(1'b0, ilp, ibp);
        tick(20);
        compare(req);
    endtask

    task automatic run_tdm(string req, logic ilp, logic ibp, int pw, int seed);
        write_cfg({ilp, ibp, 3'b010});
        n_obs = 0; n_exp = 0; n_dbl = 0;
        repeat (4) send_bit(1'b0, ~ilp, ibp);
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 256; i++) begin
                logic [23:0] v = mkval(seed, f, i / 32);
                logic [31:0] w = {1'b1, v, 7'h7F};
                send_bit(w[31 - (i % 32)], (i < pw) ? ilp : ~ilp, ibp);
                if (i % 32 == 0) begin
                    exp_ch[n_exp] = 3'(i / 32);
                    exp_d[n_exp]  = v;
                    n_exp++;
                end
            end
        end
        repeat (2) send_bit(1'b0, ~ilp, ibp);
        tick(20);
        compare(req);
    endtask

    task automatic t_reset;
        tick(3);
        check("R1 valid low in reset", int'(smp_valid), 0);
        rst_n = 1'b1; tick(3);
        check("R1 valid low after reset", int'(smp_valid), 0);
        run_stereo("R1 default I2S", 1'b0, 3'd0, 1'b0, 1'b0, 1, 1'b0);
    endtask

    task automatic t_formats;
        run_stereo("R2/R3 I2S", 1'b1, 3'd0, 1'b0, 1'b0, 2, 1'b0);
        run_stereo("R2/R4 left-justified", 1'b1, 3'd1, 1'b0, 1'b0, 3, 1'b0);
        run_stereo("R2/R5 RJ24", 1'b1, 3'd3, 1'b0, 1'b0, 4, 1'b0);
        run_stereo("R2/R5 RJ20", 1'b1, 3'd4, 1'b0, 1'b0, 5, 1'b0);
        run_stereo("R2/R5 RJ18", 1'b1, 3'd5, 1'b0, 1'b0, 6, 1'b0);
        run_stereo("R2/R5 RJ16", 1'b1, 3'd6, 1'b0, 1'b0, 7, 1'b0);
    endtask

    task automatic t_polarity;
        run_stereo("R6/R12 I2S swapped word clock", 1'b1, 3'd0, 1'b1, 1'b0, 8, 1'b0);
        run_stereo("R6/R12 LJ swapped word clock", 1'b1, 3'd1, 1'b1, 1'b0, 9, 1'b0);
        run_stereo("R7/R12 I2S falling-edge sampling", 1'b1, 3'd0, 1'b0, 1'b1, 10, 1'b0);
        run_stereo("R7/R12 RJ16 falling-edge sampling", 1'b1, 3'd6, 1'b1, 1'b1, 11, 1'b0);
    endtask

    task automatic t_tdm;
        run_tdm("R8/R9 TDM half-frame clock", 1'b0, 1'b0, 128, 12);
        run_tdm("R8/R9 TDM high pulse", 1'b1, 1'b0, 1, 13);
        run_tdm("R8/R7 TDM low pulse falling-edge sampling", 1'b0, 1'b1, 1, 14);
    endtask

    task automatic t_reserved;
        run_stereo("R10 reserved mode silent", 1'b1, 3'd7, 1'b0, 1'b0, 15, 1'b1);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(64'd20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_formats();
        t_polarity();
        t_tdm();
        t_reserved();
        finish_run();
    end
endmodule